// File: doc/BRIEF.md
# DDR2 Bank Precharge Spacing Guard

This block sits between a memory controller's command generator and a DDR2 command bus serving four banks. It decodes the active-low chip-select, row-strobe, column-strobe and write-enable lines together with the bank address and address bit 10. For every bank it keeps down-counters for three spacing rules: activate to precharge, read to precharge (both the burst-length rule and the read-to-precharge recovery window), and precharge to activate. Each bank also has a ready flag for activate and one for precharge, plus a combined ready flag for an all-bank precharge, so the command generator can pick legal work ahead of time.

Each command is forwarded to the bus one clock after it is sampled. A command that would break a rule is not forwarded. A deselect goes out in its slot instead, and a one-cycle violation pulse with a code names the rule that blocked it. Timing values arrive as clock-cycle configuration inputs: additive latency, burst length, activate-to-precharge time, precharge time and read-to-precharge recovery. The block takes these values in only while it is in reset or completely idle.

Top module: `ddr2_pre_guard`

## Requirements
- R1: Commands are decoded from the strobes (0 = low) sampled at a rising edge. Activate is cs=0, ras=0, cas=1, we=1. Read is cs=0, ras=1, cas=0, we=1. Precharge is cs=0, ras=0, cas=1, we=0. Every other encoding, including cs=1, has no timing effect and is forwarded unchanged.
- R2: For a precharge with a10=1, all four banks are targeted and the bank address is ignored. With a10=0, bank address values 0, 1, 2 and 3 select that single bank. Activates and reads always use the bank address.
- R3: A precharge to an open bank sampled k cycles after that bank's activate is held unless k >= tRAS. The code is 0. rdy_pre of the bank is 1 exactly when a precharge to it would pass.
- R4: A precharge to an open bank sampled k cycles after that bank's last read is held unless k >= AL + BL/2. The code is 1, and this rule takes priority over R5. Example: with AL=1, BL=4 and tRTP=2, a read at cycle 0 allows the precharge at cycle 3 but holds it at cycle 1.
- R5: A precharge to an open bank sampled k cycles after that bank's last read is held unless k >= AL + tRTP when BL=4, or k >= AL + 2 + tRTP when BL=8. The code is 2.
- R6: An activate to a bank sampled k cycles after that bank was closed by a precharge is held unless k >= tRP. The code is 3. rdy_act of the bank reflects this rule. tRAS (code 0) outranks both read rules.
- R7: An all-bank precharge passes only if every open bank meets R3 to R5. rdy_pre_all is the AND of the four rdy_pre flags. When it is held, the code is the highest-priority rule broken by any bank.
- R8: A precharge to an idle bank is accepted and forwarded. It leaves that bank's precharge-to-activate window untouched.
- R9: A passing command appears on the out_* pins one cycle after it is sampled, with the same values. A held command leaves all strobes high with ba=0 and a10=0 in that slot, while viol pulses for exactly that cycle with viol_code set.
- R10: The timing inputs are captured at an edge only in reset, or when all banks are closed and their tRP windows have elapsed. Changes at other times have no effect. A burst-length input other than 4 or 8 keeps the previously captured value, or selects 4 if it arrives in reset.
- R11: During and right after synchronous reset (rst_n low), all ready flags are 1, viol is 0 and the out_* strobes are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_cs_n | input | 1 | Incoming chip select, active low |
| in_ras_n | input | 1 | Incoming row strobe, active low |
| in_cas_n | input | 1 | Incoming column strobe, active low |
| in_we_n | input | 1 | Incoming write enable, active low |
| in_ba | input | BA_W | Incoming bank address |
| in_a10 | input | 1 | Incoming address bit 10 |
| cfg_al | input | AL_W | Additive latency in clocks |
| cfg_bl | input | 4 | Burst length, 4 or 8 |
| cfg_tras | input | T_W | Activate-to-precharge time in clocks |
| cfg_trp | input | T_W | Precharge-to-activate time in clocks |
| cfg_trtp | input | T_W | Read-to-precharge recovery in clocks |
| rdy_act | output | NB | Per-bank activate ready |
| rdy_pre | output | NB | Per-bank precharge ready |
| rdy_pre_all | output | 1 | All-bank precharge ready |
| out_cs_n | output | 1 | Forwarded chip select |
| out_ras_n | output | 1 | Forwarded row strobe |
| out_cas_n | output | 1 | Forwarded column strobe |
| out_we_n | output | 1 | Forwarded write enable |
| out_ba | output | BA_W | Forwarded bank address |
| out_a10 | output | 1 | Forwarded address bit 10 |
| viol | output | 1 | One-cycle pulse for a held command |
| viol_code | output | 2 | 0 tRAS, 1 read-to-precharge, 2 tRTP, 3 tRP |

## Verification
Directed sequences place precharges one cycle short of, and exactly at, each spacing limit. These separate the burst-length rule from the recovery rule, since with BL=8 and a large tRTP only the second one is still open. An all-bank precharge with one fresh bank, and a single-bank precharge to an idle bank, tell the combined rule apart from the per-bank one. A burst length of 6 presented while idle shows whether the previous value is kept. Rounds of random commands then change the configuration while banks are still open, against a timestamp model.

// File: rtl/ddr2_pg_pkg.sv
package ddr2_pg_pkg;

   typedef enum logic [1:0] {
      CMD_NOP = 2'd0,
      CMD_ACT = 2'd1,
      CMD_RD  = 2'd2,
      CMD_PRE = 2'd3
   } pg_cmd_e;

   typedef enum logic [1:0] {
      VC_TRAS   = 2'd0,
      VC_RD2PRE = 2'd1,
      VC_TRTP   = 2'd2,
      VC_TRP    = 2'd3
   } pg_vcode_e;

   // strobe encodings, ordered {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] ENC_ACT = 4'b0011;
   localparam logic [3:0] ENC_RD  = 4'b0101;
   localparam logic [3:0] ENC_PRE = 4'b0010;

endpackage

// File: rtl/ddr2_pg_decode.sv
module ddr2_pg_decode
   import ddr2_pg_pkg::*;
#(
   parameter int BA_W = 2,
   localparam int NB  = 1 << BA_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n,
   input  logic            ras_n,
   input  logic            cas_n,
   input  logic            we_n,
   input  logic [BA_W-1:0] ba,
   input  logic            a10,
   output pg_cmd_e         cmd_o,
   output logic [NB-1:0]   sel_o,
   output logic [NB-1:0]   pre_mask_o
);

   logic [3:0] strobes;
   assign strobes = {cs_n, ras_n, cas_n, we_n};

   always_comb begin
      unique case (strobes)
         ENC_ACT: cmd_o = CMD_ACT;
         ENC_RD:  cmd_o = CMD_RD;
         ENC_PRE: cmd_o = CMD_PRE;
         default: cmd_o = CMD_NOP;
      endcase
   end

   for (genvar gi = 0; gi < NB; gi++) begin : g_sel
      assign sel_o[gi] = (ba == BA_W'(gi));
   end

   assign pre_mask_o = a10 ? {NB{1'b1}} : sel_o;

   // R2: address decode names exactly one bank
   a_r2_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_o) && (sel_o != '0));

   // R2: a single-bank precharge mask follows the bank address
   a_r2_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
      !a10 |-> $countones(pre_mask_o) == 1);

endmodule

// File: rtl/ddr2_pg_cfg.sv
module ddr2_pg_cfg #(
   parameter int AL_W  = 3,
   parameter int T_W   = 5,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle,
   input  logic [AL_W-1:0]  cfg_al,
   input  logic [3:0]       cfg_bl,
   input  logic [T_W-1:0]   cfg_tras,
   input  logic [T_W-1:0]   cfg_trp,
   input  logic [T_W-1:0]   cfg_trtp,
   output logic [CNT_W-1:0] ras_ld_o,
   output logic [CNT_W-1:0] rd_ld_o,
   output logic [CNT_W-1:0] rtp_ld_o,
   output logic [CNT_W-1:0] rp_ld_o
);

   logic [AL_W-1:0] al_q;
   logic            bl8_q;
   logic [T_W-1:0]  tras_q, trp_q, trtp_q;
   logic            take;
   logic            bl_ok;

   assign take  = !rst_n || idle;
   assign bl_ok = (cfg_bl == 4'd4) || (cfg_bl == 4'd8);

   always_ff @(posedge clk) begin
      if (take) begin
         al_q   <= cfg_al;
         tras_q <= cfg_tras;
         trp_q  <= cfg_trp;
         trtp_q <= cfg_trtp;
         if (bl_ok)       bl8_q <= (cfg_bl == 4'd8);
         else if (!rst_n) bl8_q <= 1'b0;
      end
   end

   logic [CNT_W-1:0] al_w, rd_need, rtp_need, tras_w, trp_w;

   always_comb begin
      al_w     = CNT_W'(al_q);
      tras_w   = CNT_W'(tras_q);
      trp_w    = CNT_W'(trp_q);
      rd_need  = al_w + (bl8_q ? CNT_W'(4) : CNT_W'(2));
      rtp_need = al_w + (bl8_q ? CNT_W'(2) : CNT_W'(0)) + CNT_W'(trtp_q);
      ras_ld_o = (tras_w == '0)   ? '0 : tras_w - CNT_W'(1);
      rp_ld_o  = (trp_w == '0)    ? '0 : trp_w - CNT_W'(1);
      rd_ld_o  = rd_need - CNT_W'(1);
      rtp_ld_o = (rtp_need == '0) ? '0 : rtp_need - CNT_W'(1);
   end

   // R10: captured timing holds while banks are busy
   a_r10_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(al_q) && $stable(bl8_q) && $stable(tras_q)
                && $stable(trp_q) && $stable(trtp_q));

endmodule

// File: rtl/ddr2_pg_bank.sv
module ddr2_pg_bank #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_go,
   input  logic             rd_go,
   input  logic             pre_go,
   input  logic [CNT_W-1:0] ras_ld,
   input  logic [CNT_W-1:0] rd_ld,
   input  logic [CNT_W-1:0] rtp_ld,
   input  logic [CNT_W-1:0] rp_ld,
   output logic             open_o,
   output logic             rp_done_o,
   output logic             f_ras_o,
   output logic             f_rd_o,
   output logic             f_rtp_o
);

   logic             open_q;
   logic [CNT_W-1:0] ras_left, rd_left, rtp_left, rp_left;

   function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
      return (v == '0) ? '0 : v - CNT_W'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q   <= 1'b0;
         ras_left <= '0;
         rd_left  <= '0;
         rtp_left <= '0;
         rp_left  <= '0;
      end else begin
         ras_left <= step(ras_left);
         rd_left  <= step(rd_left);
         rtp_left <= step(rtp_left);
         rp_left  <= step(rp_left);
         if (act_go) begin
            open_q   <= 1'b1;
            ras_left <= ras_ld;
         end
         if (rd_go && open_q) begin
            rd_left  <= rd_ld;
            rtp_left <= rtp_ld;
         end
         if (pre_go && open_q) begin
            open_q  <= 1'b0;
            rp_left <= rp_ld;
         end
      end
   end

   assign open_o    = open_q;
   assign rp_done_o = (rp_left == '0);
   assign f_ras_o   = open_q && (ras_left != '0);
   assign f_rd_o    = open_q && (rd_left  != '0);
   assign f_rtp_o   = open_q && (rtp_left != '0);

   // R6: an activate only goes through once the precharge window is spent
   a_r6_act_after_trp: assert property (@(posedge clk) disable iff (!rst_n)
      act_go |-> rp_left == '0);

   // R3: closing an open bank waits for the activate window
   a_r3_pre_after_tras: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_go && open_q) |-> ras_left == '0);

   // R4: closing waits for the burst rule
   a_r4_pre_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_go && open_q) |-> rd_left == '0);

   // R5: closing waits for the recovery window
   a_r5_pre_after_trtp: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_go && open_q) |-> rtp_left == '0);

   // R8: a precharge to an idle bank leaves its window running down
   a_r8_idle_pre_keeps_rp: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_go && !open_q) |=>
         rp_left == (($past(rp_left) == '0) ? '0 : $past(rp_left) - CNT_W'(1)));

endmodule

// File: rtl/ddr2_pre_guard.sv
module ddr2_pre_guard
   import ddr2_pg_pkg::*;
#(
   parameter int BA_W  = 2,
   parameter int AL_W  = 3,
   parameter int T_W   = 5,
   localparam int NB    = 1 << BA_W,
   localparam int MAXV  = (1 << AL_W) + (1 << T_W) + 4,
   localparam int CNT_W = $clog2(MAXV + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_cs_n,
   input  logic            in_ras_n,
   input  logic            in_cas_n,
   input  logic            in_we_n,
   input  logic [BA_W-1:0] in_ba,
   input  logic            in_a10,
   input  logic [AL_W-1:0] cfg_al,
   input  logic [3:0]      cfg_bl,
   input  logic [T_W-1:0]  cfg_tras,
   input  logic [T_W-1:0]  cfg_trp,
   input  logic [T_W-1:0]  cfg_trtp,
   output logic [NB-1:0]   rdy_act,
   output logic [NB-1:0]   rdy_pre,
   output logic            rdy_pre_all,
   output logic            out_cs_n,
   output logic            out_ras_n,
   output logic            out_cas_n,
   output logic            out_we_n,
   output logic [BA_W-1:0] out_ba,
   output logic            out_a10,
   output logic            viol,
   output logic [1:0]      viol_code
);

   initial begin
      if (BA_W < 1 || BA_W > 3) $fatal(1, "BA_W must lie in 1..3");
      if (AL_W < 1 || AL_W > 4) $fatal(1, "AL_W must lie in 1..4");
      if (T_W < 2 || T_W > 8)   $fatal(1, "T_W must lie in 2..8");
   end

   pg_cmd_e        cmd;
   logic [NB-1:0]  sel, pre_mask;

   ddr2_pg_decode #(.BA_W(BA_W)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (in_cs_n),
      .ras_n      (in_ras_n),
      .cas_n      (in_cas_n),
      .we_n       (in_we_n),
      .ba         (in_ba),
      .a10        (in_a10),
      .cmd_o      (cmd),
      .sel_o      (sel),
      .pre_mask_o (pre_mask)
   );

   logic [CNT_W-1:0] ras_ld, rd_ld, rtp_ld, rp_ld;
   logic             idle;

   ddr2_pg_cfg #(.AL_W(AL_W), .T_W(T_W), .CNT_W(CNT_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle     (idle),
      .cfg_al   (cfg_al),
      .cfg_bl   (cfg_bl),
      .cfg_tras (cfg_tras),
      .cfg_trp  (cfg_trp),
      .cfg_trtp (cfg_trtp),
      .ras_ld_o (ras_ld),
      .rd_ld_o  (rd_ld),
      .rtp_ld_o (rtp_ld),
      .rp_ld_o  (rp_ld)
   );

   logic [NB-1:0] act_go, rd_go, pre_go;
   logic [NB-1:0] b_open, b_rp_done, b_f_ras, b_f_rd, b_f_rtp;

   for (genvar gb = 0; gb < NB; gb++) begin : g_bank
      ddr2_pg_bank #(.CNT_W(CNT_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .act_go    (act_go[gb]),
         .rd_go     (rd_go[gb]),
         .pre_go    (pre_go[gb]),
         .ras_ld    (ras_ld),
         .rd_ld     (rd_ld),
         .rtp_ld    (rtp_ld),
         .rp_ld     (rp_ld),
         .open_o    (b_open[gb]),
         .rp_done_o (b_rp_done[gb]),
         .f_ras_o   (b_f_ras[gb]),
         .f_rd_o    (b_f_rd[gb]),
         .f_rtp_o   (b_f_rtp[gb])
      );
   end

   logic       any_ras, any_rd, any_rtp, act_bad, pre_bad, hold;
   pg_vcode_e  code;

   assign idle    = (b_open == '0) && (&b_rp_done);
   assign any_ras = |(pre_mask & b_f_ras);
   assign any_rd  = |(pre_mask & b_f_rd);
   assign any_rtp = |(pre_mask & b_f_rtp);
   assign act_bad = (cmd == CMD_ACT) && ((sel & ~b_rp_done) != '0);
   assign pre_bad = (cmd == CMD_PRE) && (any_ras || any_rd || any_rtp);
   assign hold    = act_bad || pre_bad;

   always_comb begin
      if (act_bad)      code = VC_TRP;
      else if (any_ras) code = VC_TRAS;
      else if (any_rd)  code = VC_RD2PRE;
      else              code = VC_TRTP;
   end

   assign act_go = (cmd == CMD_ACT && !hold) ? sel      : '0;
   assign rd_go  = (cmd == CMD_RD)           ? sel      : '0;
   assign pre_go = (cmd == CMD_PRE && !hold) ? pre_mask : '0;

   assign rdy_act     = b_rp_done;
   assign rdy_pre     = ~(b_f_ras | b_f_rd | b_f_rtp);
   assign rdy_pre_all = &rdy_pre;

   always_ff @(posedge clk) begin
      if (!rst_n || hold) begin
         out_cs_n  <= 1'b1;
         out_ras_n <= 1'b1;
         out_cas_n <= 1'b1;
         out_we_n  <= 1'b1;
         out_ba    <= '0;
         out_a10   <= 1'b0;
      end else begin
         out_cs_n  <= in_cs_n;
         out_ras_n <= in_ras_n;
         out_cas_n <= in_cas_n;
         out_we_n  <= in_we_n;
         out_ba    <= in_ba;
         out_a10   <= in_a10;
      end
      if (!rst_n) begin
         viol      <= 1'b0;
         viol_code <= 2'd0;
      end else begin
         viol      <= hold;
         viol_code <= hold ? code : 2'd0;
      end
   end

   // R9: a violation slot carries a deselect
   a_r9_held_is_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      viol |-> out_cs_n && out_ras_n && out_cas_n && out_we_n);

   // R9: a violation is a single-cycle pulse per held command
   a_r9_pulse_tracks_hold: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> viol);

   // R7: an accepted all-bank precharge found every bank ready
   a_r7_all_needs_each: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PRE && in_a10 && !hold) |-> rdy_pre_all);

endmodule

// File: tb/sim_ddr2_pre_guard.sv
module sim_ddr2_pre_guard;

   localparam int NB = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] ba = '0;
   logic       a10 = 1'b0;
   logic [2:0] c_al_i = 3'd1;
   logic [3:0] c_bl_i = 4'd4;
   logic [4:0] c_tras_i = 5'd4, c_trp_i = 5'd3, c_trtp_i = 5'd2;

   logic [NB-1:0] rdy_act, rdy_pre;
   logic          rdy_pre_all, o_cs, o_ras, o_cas, o_we, o_a10, viol;
   logic [1:0]    o_ba, viol_code;

   always #2 clk = ~clk;   // 250 MHz

   ddr2_pre_guard u0 (
      .clk(clk), .rst_n(rst_n),
      .in_cs_n(cs_n), .in_ras_n(ras_n), .in_cas_n(cas_n), .in_we_n(we_n),
      .in_ba(ba), .in_a10(a10),
      .cfg_al(c_al_i), .cfg_bl(c_bl_i), .cfg_tras(c_tras_i),
      .cfg_trp(c_trp_i), .cfg_trtp(c_trtp_i),
      .rdy_act(rdy_act), .rdy_pre(rdy_pre), .rdy_pre_all(rdy_pre_all),
      .out_cs_n(o_cs), .out_ras_n(o_ras), .out_cas_n(o_cas), .out_we_n(o_we),
      .out_ba(o_ba), .out_a10(o_a10), .viol(viol), .viol_code(viol_code)
   );

   int n_chk = 0, n_bad = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model: timestamps per bank ----------------
   int cyc = 0;
   int m_open[NB], m_act_t[NB], m_rd_t[NB], m_pre_t[NB];
   int m_tras[NB], m_n1[NB], m_n2[NB], m_trp[NB];
   int k_al = 1, k_bl8 = 0, k_tras = 4, k_trp = 3, k_trtp = 2;
   logic [5:0] e_out;   // {cs,ras,cas,we,ba}
   logic       e_a10, e_viol, e_valid = 1'b0;
   int         e_code;
   logic [NB-1:0] e_rdy_act, e_rdy_pre;

   function automatic bit pre_ok(int b, int m);
      if (!m_open[b]) return 1'b1;
      return (m - m_act_t[b] >= m_tras[b]) && (m - m_rd_t[b] >= m_n1[b])
             && (m - m_rd_t[b] >= m_n2[b]);
   endfunction

   always @(posedge clk) begin
      int kind, tb;
      bit idle, fras, frd, frtp, bad;
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) begin
            m_open[b] = 0; m_act_t[b] = -1000; m_rd_t[b] = -1000;
            m_pre_t[b] = -1000; m_tras[b] = 0; m_n1[b] = 0; m_n2[b] = 0; m_trp[b] = 0;
         end
         k_al = c_al_i; k_tras = c_tras_i; k_trp = c_trp_i; k_trtp = c_trtp_i;
         k_bl8 = (c_bl_i == 8);
         e_out = 6'b111100; e_a10 = 0; e_viol = 0; e_code = 0;
      end else begin
         idle = 1;
         for (int b = 0; b < NB; b++)
            if (m_open[b] || (cyc - m_pre_t[b] < m_trp[b])) idle = 0;
         kind = 0;
         if ({cs_n, ras_n, cas_n, we_n} == 4'b0011) kind = 1;
         if ({cs_n, ras_n, cas_n, we_n} == 4'b0101) kind = 2;
         if ({cs_n, ras_n, cas_n, we_n} == 4'b0010) kind = 3;
         tb = ba;
         fras = 0; frd = 0; frtp = 0; bad = 0; e_code = 0;
         if (kind == 1 && (cyc - m_pre_t[tb] < m_trp[tb])) begin
            bad = 1; e_code = 3;
         end
         if (kind == 3) begin
            for (int b = 0; b < NB; b++) if ((a10 || b == tb) && m_open[b]) begin
               if (cyc - m_act_t[b] < m_tras[b]) fras = 1;
               if (cyc - m_rd_t[b] < m_n1[b])    frd = 1;
               if (cyc - m_rd_t[b] < m_n2[b])    frtp = 1;
            end
            bad = fras || frd || frtp;
            e_code = fras ? 0 : (frd ? 1 : 2);
         end
         e_viol = bad;
         if (bad) begin
            e_out = 6'b111100; e_a10 = 0; e_code = e_code;
         end else begin
            e_out = {cs_n, ras_n, cas_n, we_n, ba}; e_a10 = a10; e_code = 0;
            if (kind == 1) begin
               m_open[tb] = 1; m_act_t[tb] = cyc; m_tras[tb] = k_tras;
            end
            if (kind == 2 && m_open[tb]) begin
               m_rd_t[tb] = cyc; m_n1[tb] = k_al + (k_bl8 ? 4 : 2);
               m_n2[tb] = k_al + (k_bl8 ? 2 : 0) + k_trtp;
            end
            if (kind == 3)
               for (int b = 0; b < NB; b++) if ((a10 || b == tb) && m_open[b]) begin
                  m_open[b] = 0; m_pre_t[b] = cyc; m_trp[b] = k_trp;
               end
         end
         if (bad && kind == 1) e_code = 3;
         else if (bad) e_code = fras ? 0 : (frd ? 1 : 2);
         if (idle) begin
            k_al = c_al_i; k_tras = c_tras_i; k_trp = c_trp_i; k_trtp = c_trtp_i;
            if (c_bl_i == 4 || c_bl_i == 8) k_bl8 = (c_bl_i == 8);
         end
      end
      cyc++;
      for (int b = 0; b < NB; b++) begin
         e_rdy_act[b] = (cyc - m_pre_t[b] >= m_trp[b]);
         e_rdy_pre[b] = pre_ok(b, cyc);
      end
      e_valid = 1'b1;
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (e_valid) begin
         string vt;
         vt = (e_code == 0) ? "R3" : (e_code == 1) ? "R4" : (e_code == 2) ? "R5" : "R6";
         chk({o_cs, o_ras, o_cas, o_we, o_ba} == e_out && o_a10 == e_a10, "R9 forward",
             {o_cs, o_ras, o_cas, o_we, o_ba}, e_out);
         chk(viol == e_viol, "R9 viol pulse", viol, e_viol);
         if (e_viol) chk(viol_code == e_code[1:0], vt, viol_code, e_code);
         chk(rdy_act == e_rdy_act, "R6 rdy_act", rdy_act, e_rdy_act);
         chk(rdy_pre == e_rdy_pre, "R3 rdy_pre", rdy_pre, e_rdy_pre);
         chk(rdy_pre_all == (&e_rdy_pre), "R7 rdy_pre_all", rdy_pre_all, &e_rdy_pre);
      end
   end

   // watchdog
   always @(posedge clk) if (cyc > 60000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=60000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   // kind: 0 NOP, 1 ACT, 2 RD, 3 PRE, 4 write-like encoding
   task automatic issue(input int kind, input int b, input bit a);
      case (kind)
         1: {cs_n, ras_n, cas_n, we_n} = 4'b0011;
         2: {cs_n, ras_n, cas_n, we_n} = 4'b0101;
         3: {cs_n, ras_n, cas_n, we_n} = 4'b0010;
         4: {cs_n, ras_n, cas_n, we_n} = 4'b0100;
         default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      endcase
      ba = 2'(b); a10 = a;
      @(negedge clk);
   endtask

   task automatic idle_n(input int n);
      for (int i = 0; i < n; i++) issue(0, 0, 1'b0);
   endtask

   task automatic set_cfg(input int al, input int bl, input int tras, input int trp, input int trtp);
      c_al_i = 3'(al); c_bl_i = 4'(bl); c_tras_i = 5'(tras); c_trp_i = 5'(trp); c_trtp_i = 5'(trtp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(rdy_act == '1 && rdy_pre == '1 && rdy_pre_all, "R11 ready in reset",
          {rdy_act, rdy_pre}, 8'hff);
      chk(!viol && o_cs && o_ras && o_cas && o_we, "R11 outputs in reset",
          {viol, o_cs, o_ras, o_cas, o_we}, 5'b01111);
      rst_n = 1'b1;

      // AL=1 BL=4 tRAS=4 tRP=3 tRTP=2
      issue(1, 0, 0); idle_n(4);
      issue(2, 0, 0);                         // read at cycle 0
      issue(3, 0, 0);                         // cycle 1
      chk(viol && viol_code == 2'd1, "R4 early pre held", viol_code, 1);
      issue(0, 0, 0);
      issue(3, 0, 0);                         // cycle 3
      chk(!viol && !o_ras && o_cas && !o_we, "R4 pre at AL+BL/2 passes", viol, 0);
      issue(1, 0, 0);
      chk(viol && viol_code == 2'd3, "R6 act inside tRP", viol_code, 3);
      issue(3, 2, 0);
      chk(!viol && o_ba == 2'd2 && !o_cs, "R8 idle-bank pre forwarded", viol, 0);
      chk(rdy_act[2] == 1'b1, "R8 idle-bank tRP untouched", rdy_act[2], 1);
      issue(1, 1, 0); issue(3, 1, 0);
      chk(viol && viol_code == 2'd0, "R3 pre inside tRAS", viol_code, 0);
      issue(1, 3, 0); issue(3, 2, 1);
      chk(viol && viol_code == 2'd0, "R7 all-bank pre blocked by one bank", viol_code, 0);
      idle_n(4);
      issue(3, 2, 1);
      chk(!viol && o_a10, "R2 all-bank pre passes", viol, 0);
      chk(rdy_act[1] == 0 && rdy_act[3] == 0 && rdy_act[0] && rdy_act[2],
          "R2 a10 closes every open bank", rdy_act, 4'b0101);
      issue(4, 1, 0);
      chk(!viol && !o_cs && o_ras && !o_cas && !o_we && o_ba == 2'd1,
          "R1 other encoding forwarded", {o_cs, o_ras, o_cas, o_we}, 4'b0100);
      idle_n(6);

      // AL=0 BL=8 tRAS=1 tRP=1 tRTP=5: burst rule 4, recovery rule 7
      set_cfg(0, 8, 1, 1, 5); idle_n(2);
      issue(1, 0, 0); issue(0, 0, 0);
      issue(2, 0, 0); idle_n(4);
      issue(3, 0, 0);                         // cycle 5
      chk(viol && viol_code == 2'd2, "R5 pre inside tRTP window", viol_code, 2);
      issue(0, 0, 0);
      issue(3, 0, 0);                         // cycle 7
      chk(!viol, "R5 pre at AL+2+tRTP passes", viol, 0);
      idle_n(4);

      // BL=6 is rejected, BL=8 kept: burst rule 4, recovery rule 2
      set_cfg(0, 6, 1, 1, 0); idle_n(2);
      issue(1, 0, 0); issue(0, 0, 0);
      issue(2, 0, 0); idle_n(2);
      issue(3, 0, 0);                         // cycle 3
      chk(viol && viol_code == 2'd1, "R10 invalid BL keeps previous", viol_code, 1);
      issue(3, 0, 0);                         // cycle 4
      chk(!viol, "R10 pre at kept burst rule", viol, 0);

      // random rounds, configuration changed while banks are busy
      for (int r = 0; r < 6; r++) begin
         int bls[4] = '{4, 8, 6, 4};
         set_cfg($urandom_range(0, 3), bls[$urandom_range(0, 3)], $urandom_range(0, 12),
                 $urandom_range(0, 6), $urandom_range(0, 6));
         for (int i = 0; i < 500; i++)
            issue($urandom_range(0, 4), $urandom_range(0, 3), 1'($urandom_range(0, 5) == 0));
      end
      idle_n(2);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule